// File: doc/BRIEF.md
# Column Forward DCT Butterfly (8-point, fixed point)

This block computes the one-dimensional forward discrete cosine transform of one column of eight signed 16-bit samples. It is the vertical half of a separable 8x8 transform: a later row stage, quantiser or transposition memory takes its eight 16-bit results. The arithmetic follows a fast factorisation that turns the rotations into tangent-scaled multiplies. Every constant multiply keeps only the upper half of a signed 16x16 product. Every sum and difference clamps to the signed 16-bit range.

A column is offered on `in_col` with `in_valid` and taken when `in_ready` is high. The result appears on `out_col` with `out_valid` a fixed number of cycles later, and it is held there until `out_ready` accepts it. The whole pipeline advances as one unit, so a held output stalls every stage behind it. The parameter `SHIFT` sets the pre-scaling of the intermediates. The parameter `MID_REG` chooses whether a register splits the rotation stage from the odd stage (latency 3) or not (latency 2).

Top module: `col_dct8_fwd`

## Requirements
- R1: With `out_ready` held high, a column accepted at a rising edge appears on `out_col` with `out_valid` high after exactly 2+`MID_REG` rising edges (3 by default), and columns leave in the order they were accepted.
- R2: A constant product is bits [31:16] of the signed 32-bit product of a sample and a constant. Every sum and difference clamps to [-32768, 32767]. The constants are 0x32EC (tan pi/16), 0x6A0A (tan 2pi/16), 0xAB0E (tan 3pi/16 minus one, taken as signed) and 0x5A82 (half of 1/sqrt 2).
- R3: The input sample in lane k (k = 0..7) is written s_k. The input stage forms a0=s0+s7, a7=s0-s7, a1=s1+s6, a6=s1-s6, a2=s2+s5, a5=s2-s5, a3=s3+s4 and a4=s3-s4. It then forms e03=a0+a3, d03=a0-a3, e12=a1+a2 and d12=a1-a2. a5 and a6 are shifted left by `SHIFT`+1, and e03, d03, e12, d12, a4 and a7 by `SHIFT`. A shift keeps the low 16 bits and does not clamp.
- R4: out0 = e03+e12 and out4 = e03-e12.
- R5: out2 = d03 + (d12 times 0x6A0A) and out6 = (d03 times 0x6A0A) - d12. Bit 0 of both is then forced to 1.
- R6: rp = (a6+a5) times 0x5A82, with bit 0 forced to 1, and rm = (a6-a5) times 0x5A82. From these, u = a4+rm, v = a4-rm, p = a7+rp and m = a7-rp. Then out1 = p + (u times 0x32EC) and out7 = (p times 0x32EC) - u.
- R7: A product by tan 3pi/16 is formed as (x times 0xAB0E) + x. out3 = m - that product of v, and out5 = v + that product of m.
- R8: While `out_valid` is high and `out_ready` is low, `out_col` and `out_valid` hold their values and `in_ready` is low.
- R9: During and right after reset, `out_valid` is low and `in_ready` is high.
- R10: On both `in_col` and `out_col`, lane k occupies bits [16k+15:16k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A column is offered on in_col |
| in_ready | output | 1 | The block takes the offered column at this edge |
| in_col | input | 128 | Eight signed input samples, lane k at [16k+15:16k] |
| out_valid | output | 1 | out_col holds a finished column |
| out_ready | input | 1 | The consumer takes out_col at this edge |
| out_col | output | 128 | Eight signed DCT outputs, lane k at [16k+15:16k] |

## Verification
The clocked checks assume that the handshake inputs and `in_col` are known values that change only between clock edges, and that reset is held for at least one edge. The immediate checks on the combinational stages assume a fully defined column. The bench sets every input before it releases reset. It changes inputs one time unit after a rising edge and reads results at the falling edge, so no check depends on the order of events at an edge. Its stimulus mixes small values, full-range values and clamping extremes, and it toggles `out_ready` pseudo-randomly so that stalls land in every pipeline position.

// File: rtl/dct8_pkg.sv
package dct8_pkg;

   localparam int SW    = 16;
   localparam int LANES = 8;

   typedef logic signed [SW-1:0]       smp_t;
   typedef logic [LANES-1:0][SW-1:0]   vec8_t;

   localparam smp_t K_TAN1   = 16'sh32EC;
   localparam smp_t K_TAN2   = 16'sh6A0A;
   localparam smp_t K_TAN3M1 = 16'shAB0E;
   localparam smp_t K_HRT2   = 16'sh5A82;

   localparam smp_t S_MAX = {1'b0, {(SW-1){1'b1}}};
   localparam smp_t S_MIN = {1'b1, {(SW-1){1'b0}}};

   // intermediates after the input butterflies and pre-shift
   typedef struct packed {
      smp_t e03;
      smp_t d03;
      smp_t e12;
      smp_t d12;
      smp_t a4;
      smp_t a5;
      smp_t a6;
      smp_t a7;
   } front_t;

   // even outputs plus odd-path terms after the rotation stage
   typedef struct packed {
      smp_t o0;
      smp_t o2;
      smp_t o4;
      smp_t o6;
      smp_t a4;
      smp_t a7;
      smp_t rp;
      smp_t rm;
   } mid_t;

   function automatic smp_t clamp17(logic [SW:0] w);
      if (w[SW] != w[SW-1])
         return w[SW] ? S_MIN : S_MAX;
      return smp_t'(w[SW-1:0]);
   endfunction

   function automatic smp_t sadd(smp_t a, smp_t b);
      logic [SW:0] w;
      w = {a[SW-1], a} + {b[SW-1], b};
      return clamp17(w);
   endfunction

   function automatic smp_t ssub(smp_t a, smp_t b);
      logic [SW:0] w;
      w = {a[SW-1], a} - {b[SW-1], b};
      return clamp17(w);
   endfunction

   function automatic smp_t mulh(smp_t a, smp_t k);
      logic signed [2*SW-1:0] p;
      p = (2*SW)'(a) * (2*SW)'(k);
      return smp_t'(p[2*SW-1:SW]);
   endfunction

   function automatic smp_t shl(smp_t a, int unsigned s);
      return a << s;
   endfunction

   function automatic smp_t set_lsb(smp_t a);
      return {a[SW-1:1], 1'b1};
   endfunction

endpackage

// File: rtl/dct8_front.sv
module dct8_front
   import dct8_pkg::*;
#(
   parameter int SHIFT = 3
) (
   input  vec8_t  x,
   output front_t y
);

   smp_t sm [4];
   smp_t df [4];

   // mirrored-lane butterflies: lane k paired with lane 7-k
   for (genvar k = 0; k < 4; k++) begin : g_bfly
      assign sm[k] = sadd(smp_t'(x[k]), smp_t'(x[LANES-1-k]));
      assign df[k] = ssub(smp_t'(x[k]), smp_t'(x[LANES-1-k]));
   end

   always_comb begin
      y.e03 = shl(sadd(sm[0], sm[3]), SHIFT);
      y.d03 = shl(ssub(sm[0], sm[3]), SHIFT);
      y.e12 = shl(sadd(sm[1], sm[2]), SHIFT);
      y.d12 = shl(ssub(sm[1], sm[2]), SHIFT);
      y.a4  = shl(df[3], SHIFT);
      y.a5  = shl(df[2], SHIFT + 1);
      y.a6  = shl(df[1], SHIFT + 1);
      y.a7  = shl(df[0], SHIFT);
   end

   always_comb begin : chk
      // R3
      if (x == '0) begin
         zero_in_chk: assert (y == '0)
            else $error("front stage: zero column gave nonzero terms");
      end
   end

endmodule

// File: rtl/dct8_mid.sv
module dct8_mid
   import dct8_pkg::*;
(
   input  front_t a,
   output mid_t   b
);

   always_comb begin
      b.o0 = sadd(a.e03, a.e12);
      b.o4 = ssub(a.e03, a.e12);
      b.o2 = set_lsb(sadd(mulh(a.d12, K_TAN2), a.d03));
      b.o6 = set_lsb(ssub(mulh(a.d03, K_TAN2), a.d12));
      b.rp = set_lsb(mulh(sadd(a.a6, a.a5), K_HRT2));
      b.rm = mulh(ssub(a.a6, a.a5), K_HRT2);
      b.a4 = a.a4;
      b.a7 = a.a7;
   end

   always_comb begin : chk
      // R4
      if (a.e12 == '0) begin
         even_sym_chk: assert (b.o0 == b.o4)
            else $error("mid stage: even pair differs with zero e12");
      end
   end

endmodule

// File: rtl/dct8_odd.sv
module dct8_odd
   import dct8_pkg::*;
(
   input  mid_t  b,
   output vec8_t y
);

   smp_t u, v, p, m;
   smp_t v_t3, m_t3;

   always_comb begin
      u    = sadd(b.a4, b.rm);
      v    = ssub(b.a4, b.rm);
      p    = sadd(b.a7, b.rp);
      m    = ssub(b.a7, b.rp);
      // tan(3pi/16) split as (t-1)*x + x so the constant stays in 16 bits
      v_t3 = sadd(mulh(v, K_TAN3M1), v);
      m_t3 = sadd(mulh(m, K_TAN3M1), m);

      y[0] = b.o0;
      y[2] = b.o2;
      y[4] = b.o4;
      y[6] = b.o6;
      y[1] = sadd(p, mulh(u, K_TAN1));
      y[7] = ssub(mulh(p, K_TAN1), u);
      y[3] = ssub(m, v_t3);
      y[5] = sadd(v, m_t3);
   end

endmodule

// File: rtl/dct8_pipe_reg.sv
module dct8_pipe_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         vi,
   input  logic [W-1:0] di,
   output logic         vo,
   output logic [W-1:0] dq
);

   if (W < 1) begin : g_bad_w
      $error("dct8_pipe_reg: W must be positive");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vo <= 1'b0;
         dq <= '0;
      end else if (en) begin
         vo <= vi;
         dq <= di;
      end
   end

endmodule

// File: rtl/col_dct8_fwd.sv
module col_dct8_fwd
   import dct8_pkg::*;
#(
   parameter int SHIFT   = 3,
   parameter bit MID_REG = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   output logic                  in_ready,
   input  logic [LANES*SW-1:0]   in_col,
   output logic                  out_valid,
   input  logic                  out_ready,
   output logic [LANES*SW-1:0]   out_col
);

   localparam int LATENCY = 2 + int'(MID_REG);
   localparam int FW      = $bits(front_t);
   localparam int MW      = $bits(mid_t);
   localparam int VW      = $bits(vec8_t);

   if (SHIFT < 0 || SHIFT > 12) begin : g_bad_shift
      $error("col_dct8_fwd: SHIFT must lie in 0..12");
   end
   if (LATENCY < 2 || LATENCY > 3) begin : g_bad_lat
      $error("col_dct8_fwd: latency out of range");
   end

   logic   adv;
   vec8_t  in_v;
   front_t f_c, f_q;
   mid_t   m_c, m_q;
   vec8_t  o_c, o_q;
   logic   v1, v2;

   assign adv      = !out_valid || out_ready;
   assign in_ready = adv;
   assign in_v     = in_col;

   dct8_front #(.SHIFT(SHIFT)) u_front (.x(in_v), .y(f_c));

   dct8_pipe_reg #(.W(FW)) u_r1 (
      .clk(clk), .rst_n(rst_n), .en(adv),
      .vi(in_valid), .di(f_c), .vo(v1), .dq(f_q)
   );

   dct8_mid u_mid (.a(f_q), .b(m_c));

   if (MID_REG) begin : g_mid_reg
      dct8_pipe_reg #(.W(MW)) u_r2 (
         .clk(clk), .rst_n(rst_n), .en(adv),
         .vi(v1), .di(m_c), .vo(v2), .dq(m_q)
      );
   end else begin : g_mid_wire
      assign v2  = v1;
      assign m_q = m_c;
   end

   dct8_odd u_odd (.b(m_q), .y(o_c));

   dct8_pipe_reg #(.W(VW)) u_r3 (
      .clk(clk), .rst_n(rst_n), .en(adv),
      .vi(v2), .di(o_c), .vo(out_valid), .dq(o_q)
   );

   assign out_col = o_q;

   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_col))
      else $error("held output changed");

   // R8
   stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |-> out_valid)
      else $error("input stalled with no output pending");

   // R9
   rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> !out_valid && in_ready)
      else $error("valid output right after reset");

   // R5
   odd_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_col[2*SW] && out_col[6*SW])
      else $error("forced rounding bit missing");

endmodule

// File: tb/col_dct8_fwd_tb.sv
module col_dct8_fwd_tb;

   localparam int CLK_PERIOD = 10;
   localparam int SHIFT      = 3;
   localparam bit MID_REG    = 1'b1;
   localparam int EXP_LAT    = 3;
   localparam int QD         = 4096;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [127:0] in_col = '0;
   logic         out_valid;
   logic         out_ready = 1'b1;
   logic [127:0] out_col;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc   = 0;

   logic [127:0] expq [QD];
   bit           extq [QD];
   int           wr = 0;
   int           rd = 0;
   bit           ext_flag = 1'b0;
   int           rdy_mode = 0;
   int unsigned  rs = 32'h1234_5678;
   int unsigned  rs2 = 32'h0bad_cafe;

   col_dct8_fwd #(.SHIFT(SHIFT), .MID_REG(MID_REG)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_col(in_col), .out_valid(out_valid), .out_ready(out_ready),
      .out_col(out_col)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // ---------------- arithmetic model ----------------
   function automatic int sat(int v);
      if (v > 32767) return 32767;
      if (v < -32768) return -32768;
      return v;
   endfunction

   function automatic int w16(int v);
      logic [15:0] b;
      b = v[15:0];
      return int'($signed(b));
   endfunction

   function automatic int mh(int a, int c);
      int p;
      p = a * c;
      return p >>> 16;
   endfunction

   function automatic logic [127:0] model(logic [127:0] v);
      int s [8];
      int a0, a1, a2, a3, a4, a5, a6, a7;
      int e03, d03, e12, d12, rp, rm, u, vv, p, m;
      int o [8];
      logic [127:0] r;
      for (int k = 0; k < 8; k++) s[k] = int'($signed(v[16*k +: 16]));
      a0 = sat(s[0] + s[7]); a7 = sat(s[0] - s[7]);
      a1 = sat(s[1] + s[6]); a6 = sat(s[1] - s[6]);
      a2 = sat(s[2] + s[5]); a5 = sat(s[2] - s[5]);
      a3 = sat(s[3] + s[4]); a4 = sat(s[3] - s[4]);
      e03 = w16(sat(a0 + a3) << SHIFT);
      d03 = w16(sat(a0 - a3) << SHIFT);
      e12 = w16(sat(a1 + a2) << SHIFT);
      d12 = w16(sat(a1 - a2) << SHIFT);
      a4  = w16(a4 << SHIFT);
      a7  = w16(a7 << SHIFT);
      a5  = w16(a5 << (SHIFT + 1));
      a6  = w16(a6 << (SHIFT + 1));
      o[0] = sat(e03 + e12);
      o[4] = sat(e03 - e12);
      o[2] = sat(mh(d12, 27146) + d03) | 1;
      o[6] = sat(mh(d03, 27146) - d12) | 1;
      rp = mh(sat(a6 + a5), 23170) | 1;
      rm = mh(sat(a6 - a5), 23170);
      u  = sat(a4 + rm);
      vv = sat(a4 - rm);
      p  = sat(a7 + rp);
      m  = sat(a7 - rp);
      o[1] = sat(p + mh(u, 13036));
      o[7] = sat(mh(p, 13036) - u);
      o[3] = sat(m - sat(mh(vv, -21746) + vv));
      o[5] = sat(vv + sat(mh(m, -21746) + m));
      for (int k = 0; k < 8; k++) r[16*k +: 16] = o[k][15:0];
      return r;
   endfunction

   function automatic string tag_of(int k, bit ext);
      if (ext) return "R2";
      case (k)
         0, 4:    return "R4 R3 R10";
         2, 6:    return "R5";
         default: return "R6 R7";
      endcase
   endfunction

   // ---------------- scoreboard (sampled at falling edge) ----------------
   always @(negedge clk) begin
      if (rst_n && in_valid && in_ready) begin
         expq[wr % QD] = model(in_col);
         extq[wr % QD] = ext_flag;
         wr++;
      end
      if (rst_n && out_valid && out_ready) begin
         n_cmp++;
         if (rd >= wr) begin
            n_bad++;
            $display("FAIL R1 unexpected output got %h exp none", out_col);
         end else begin
            logic [127:0] e;
            bit bad;
            e = expq[rd % QD];
            bad = 1'b0;
            for (int k = 0; k < 8; k++) begin
               if (out_col[16*k +: 16] !== e[16*k +: 16]) begin
                  bad = 1'b1;
                  $display("FAIL %s lane %0d got %h exp %h", tag_of(k, extq[rd % QD]),
                           k, out_col[16*k +: 16], e[16*k +: 16]);
               end
            end
            if (bad) n_bad++;
            rd++;
         end
      end
   end

   // ---------------- out_ready driver ----------------
   always @(posedge clk) begin
      #1;
      rs2 = rs2 ^ (rs2 << 13); rs2 = rs2 ^ (rs2 >> 17); rs2 = rs2 ^ (rs2 << 5);
      case (rdy_mode)
         0:       out_ready = 1'b1;
         1:       out_ready = rs2[3] | rs2[9];
         default: out_ready = 1'b0;
      endcase
   end

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_bad++;
         $display("FAIL R1 watchdog expired got cycle %0d exp finish", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   // ---------------- stimulus helpers ----------------
   function automatic int unsigned nxt();
      rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
      return rs;
   endfunction

   task automatic send(input logic [127:0] v, input bit ext);
      @(posedge clk); #1;
      in_col = v; in_valid = 1'b1; ext_flag = ext;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
   endtask

   task automatic idle();
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   task automatic check(input bit ok, input string what, input int got, input int exp_v);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s got %0d exp %0d", what, got, exp_v);
      end
   endtask

   function automatic logic [127:0] splat(int val);
      logic [127:0] r;
      for (int k = 0; k < 8; k++) r[16*k +: 16] = val[15:0];
      return r;
   endfunction

   initial begin
      logic [127:0] v;
      logic [127:0] snap;
      logic [127:0] ev;
      int cnt;

      // R9: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(out_valid == 1'b0, "R9 out_valid in reset", int'(out_valid), 0);
      check(in_ready == 1'b1, "R9 in_ready in reset", int'(in_ready), 1);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R9 out_valid after reset", int'(out_valid), 0);

      // R1: latency from acceptance to first valid output
      @(posedge clk); #1;
      in_col = splat(5); in_valid = 1'b1; ext_flag = 1'b0;
      @(posedge clk); #1 in_valid = 1'b0;
      cnt = 0;
      do begin
         @(negedge clk);
         cnt++;
      end while (!out_valid && cnt < 20);
      check(cnt == EXP_LAT, "R1 latency", cnt, EXP_LAT);
      repeat (4) @(posedge clk);

      // R10 R3 R4 R5 R6: single-lane impulses of several sizes
      foreach (v[i]) v[i] = 1'b0;
      for (int k = 0; k < 8; k++) begin
         for (int j = 0; j < 6; j++) begin
            int amp;
            case (j)
               0: amp = 1;   1: amp = -1;   2: amp = 100;
               3: amp = -255; 4: amp = 1000; default: amp = -2048;
            endcase
            v = '0;
            v[16*k +: 16] = amp[15:0];
            send(v, 1'b0);
         end
      end
      // DC and ramps
      send(splat(255), 1'b0);
      send(splat(-256), 1'b0);
      for (int k = 0; k < 8; k++) v[16*k +: 16] = 16'(k * 37 - 130);
      send(v, 1'b0);

      // R2: clamping extremes
      send(splat(32767), 1'b1);
      send(splat(-32768), 1'b1);
      for (int k = 0; k < 8; k++) v[16*k +: 16] = k[0] ? 16'h8000 : 16'h7FFF;
      send(v, 1'b1);
      for (int k = 0; k < 8; k++) v[16*k +: 16] = (k < 4) ? 16'h7FFF : 16'h8000;
      send(v, 1'b1);
      for (int k = 0; k < 8; k++) v[16*k +: 16] = (k == 1 || k == 2) ? 16'h7FFF : 16'h8001;
      send(v, 1'b1);
      idle();
      repeat (6) @(posedge clk);

      // R8: stall with out_ready low holds everything
      rdy_mode = 2;
      @(posedge clk);
      send(splat(77) ^ 128'h0123_4567_89ab_cdef_0f1e_2d3c_4b5a_6978, 1'b0);
      ev = model(in_col);
      idle();
      repeat (6) @(negedge clk);
      check(out_valid == 1'b1, "R8 out_valid while stalled", int'(out_valid), 1);
      check(in_ready == 1'b0, "R8 in_ready while stalled", int'(in_ready), 0);
      snap = out_col;
      check(snap == ev, "R8 held value", int'(snap[15:0]), int'(ev[15:0]));
      repeat (3) @(negedge clk);
      check(out_col == snap && out_valid, "R8 held value stable",
            int'(out_col[15:0]), int'(snap[15:0]));
      rdy_mode = 0;
      repeat (4) @(posedge clk);

      // R1 R6 R7: long pseudo-random stream with random back-pressure
      rdy_mode = 1;
      for (int n = 0; n < 2500; n++) begin
         int unsigned r;
         r = nxt();
         for (int k = 0; k < 8; k++) begin
            int unsigned w;
            w = nxt();
            case (r[1:0])
               2'd0:    v[16*k +: 16] = 16'($signed(w[8:0]));
               2'd1:    v[16*k +: 16] = 16'($signed(w[11:0]));
               default: v[16*k +: 16] = w[15:0];
            endcase
         end
         send(v, r[1:0] == 2'd2);
      end
      idle();
      rdy_mode = 0;

      // R1: every accepted column delivered
      cnt = 0;
      while (rd != wr && cnt < 100) begin
         @(negedge clk);
         cnt++;
      end
      check(rd == wr, "R1 all columns delivered", rd, wr);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule